// File: doc/BRIEF.md
# Nibble handshake host port

This block is the device end of a byte link to a host processor. The link is a 4-bit data bus plus two pairs of active-low handshake lines: a request/accept pair for host-to-device transfers (downloads) and a request/accept pair for device-to-host transfers (uploads). Every byte crosses the link as two nibbles, and every nibble needs a full four-phase handshake, so either side may stall at any step.

The first byte of each transfer is a control byte. It picks one of two classes. A data packet carries its own length and is written byte by byte into an external packet buffer. A memory access reads or writes a 64-entry byte register file. Entry 0 of that file holds the switch flags. The radio side loads received packets into an internal receive buffer and commits them. A committed packet is offered to the host before any new download is accepted. An optional host timeout releases the link when the host stops answering in the middle of a transfer.

Top module: `nibble_host_port`

## Requirements
- R1: During and after reset, txAckN and rxReqN are high, busOe is low and all 64 register file entries read back as 00h.
- R2: A download nibble runs as follows. The host pulls txReqN low and the port answers with txAckN low. The host puts the nibble on busIn and raises txReqN. The port captures the nibble and raises txAckN. The port never lowers txAckN while the synchronised request is high.
- R3: Each byte crosses the bus as bits 3:0 first and bits 7:4 second, in both directions.
- R4: Control bit 7 = 0 marks a data packet with its length in bits 4:0. A length above MAX_DATA (27) is treated as 27. The control byte and then the data bytes go out on the buffer write port at addresses 0 to length. A one-cycle pktDone pulse follows the last byte. A length of 0 writes only the control byte.
- R5: An upload nibble runs as follows. The port pulls rxReqN low and the host answers with rxAckN low. The port drives busOut, sets busOe and raises rxReqN. The host then raises rxAckN. busOe stays high from the first granted nibble to the end of the last nibble, and it is low in every other state.
- R6: Control bits 7:6 = 10 mark a memory read of the address in bits 5:0. The port uploads two bytes: the control byte echoed back, then the register content.
- R7: Control bits 7:6 = 11 mark a memory write. The port takes one further data byte and uploads nothing.
- R8: Switch bit 0 is the write enable. Writes to address 00h always take effect. A write to 01h–3Fh takes effect only while that bit is set and clears the bit. Otherwise the target keeps its old value.
- R9: A rxCommit pulse marks the receive buffer as pending. While a packet is pending, a download request is not granted. The port first uploads the packet: its control byte and then its length (bits 4:0, limited to 27) in data bytes. A request that is still held is granted once the upload ends.
- R10: Switch bit 1 enables the host timeout. If it is set and TIMEOUT_TICKS msTick pulses pass without a handshake step in the middle of a transfer, the port raises both of its handshake lines, drops busOe and discards any pending packet. It then waits until txReqN and rxAckN are both high before it accepts new work. With the bit clear, the port waits without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle millisecond tick for the host timeout |
| txReqN | input | 1 | Download request from the host, active low |
| txAckN | output | 1 | Download accept to the host, active low |
| rxReqN | output | 1 | Upload request to the host, active low |
| rxAckN | input | 1 | Upload accept from the host, active low |
| busIn | input | 4 | Nibble driven by the host |
| busOut | output | 4 | Nibble driven by the port |
| busOe | output | 1 | Output enable for busOut onto the shared bus |
| rxWrEn | input | 1 | Receive buffer write strobe from the radio side |
| rxWrAddr | input | IDX_W | Receive buffer write address |
| rxWrData | input | 8 | Receive buffer write data |
| rxCommit | input | 1 | Marks the receive buffer contents as a pending packet |
| bufWrEn | output | 1 | Packet buffer write strobe for downloaded data packets |
| bufWrAddr | output | IDX_W | Packet buffer write address |
| bufWrData | output | 8 | Packet buffer write data |
| pktDone | output | 1 | One-cycle pulse after the last byte of a data packet |

## Verification
The main function is driven through memory write and readback vectors. These separate enabled writes from locked writes to low and high addresses, and confirm the write enable clears after use. Data packets of length 3, 0 and an over-long 31 tell nibble ordering apart from length decoding and clamping. A pending received packet together with a held download request shows whether the upload is served first. Two stalled handshakes, one with the timeout enabled and one without, tell the abort path apart from waiting without limit.

// File: rtl/nhp_pkg.sv
package nhp_pkg;

  // switch register (register file entry 0) bit positions
  localparam int WE_BIT  = 0;
  localparam int HTO_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DL_WAIT,
    ST_DL_ACK,
    ST_UL_REQ,
    ST_UL_DRV,
    ST_HOLD
  } portState_e;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic latchLo;    // capture low nibble
    logic byteDone;   // high nibble present, byte complete
    logic dataWr;     // byte belongs to a data packet
    logic memWr;      // register file write with the held control byte
    logic hiNib;      // upload: present high nibble
    logic replyMode;  // upload source: 1 = memory reply, 0 = receive buffer
  } dpStrobe_t;

endpackage

// File: rtl/nhp_sync.sv
module nhp_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RESET_VAL[b]}};
      else       chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/nhp_datapath.sv
module nhp_datapath
  import nhp_pkg::*;
#(
  parameter int MAX_DATA = 27,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       busIn,
  input  dpStrobe_t        strobe,
  input  logic [IDX_W-1:0] idx,
  output logic [1:0]       ctlType,
  output logic [IDX_W-1:0] asmCount,
  output logic [IDX_W-1:0] rxCount,
  output logic             htoEn,
  output logic [3:0]       busOut,
  input  logic             rxWrEn,
  input  logic [IDX_W-1:0] rxWrAddr,
  input  logic [7:0]       rxWrData,
  output logic             bufWrEn,
  output logic [IDX_W-1:0] bufWrAddr,
  output logic [7:0]       bufWrData
);

  localparam int BUF_DEPTH = MAX_DATA + 1;
  localparam int ADDR_W = 6;               // fixed by the control byte layout
  localparam int REG_COUNT = 1 << ADDR_W;
  localparam int CNT_BITS = 5;             // length field width in the control byte

  logic [3:0] lowNib;
  logic [7:0] asmByte;
  logic [7:0] ctlReg;
  logic [7:0] regs [REG_COUNT];
  logic [7:0] rxBuf [BUF_DEPTH];
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] upByte;

  assign asmByte = {busIn, lowNib};
  assign ctlType = asmByte[7:6];
  assign memAddr = ctlReg[ADDR_W-1:0];
  assign htoEn = regs[0][HTO_BIT];

  function automatic logic [IDX_W-1:0] clampLen(input logic [CNT_BITS-1:0] raw);
    if (int'(raw) > MAX_DATA) return IDX_W'(MAX_DATA);
    return IDX_W'(raw);
  endfunction

  assign asmCount = clampLen(asmByte[CNT_BITS-1:0]);
  assign rxCount  = clampLen(rxBuf[0][CNT_BITS-1:0]);

  // nibble assembly and control byte hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowNib <= '0;
      ctlReg <= '0;
    end else begin
      if (strobe.latchLo) lowNib <= busIn;
      if (strobe.byteDone && idx == '0) ctlReg <= asmByte;
    end
  end

  // packet buffer write port, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
    end else begin
      bufWrEn <= strobe.byteDone && strobe.dataWr;
      if (strobe.byteDone) begin
        bufWrAddr <= idx;
        bufWrData <= asmByte;
      end
    end
  end

  // register file with guarded writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (strobe.memWr) begin
      if (memAddr == '0) begin
        regs[0] <= asmByte;
      end else if (regs[0][WE_BIT]) begin
        regs[memAddr] <= asmByte;
        regs[0][WE_BIT] <= 1'b0;
      end
    end
  end

  // receive buffer loaded by the radio side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) rxBuf[i] <= '0;
    end else if (rxWrEn && int'(rxWrAddr) < BUF_DEPTH) begin
      rxBuf[rxWrAddr] <= rxWrData;
    end
  end

  // upload byte and nibble selection
  always_comb begin
    if (strobe.replyMode) upByte = (idx == '0) ? ctlReg : regs[memAddr];
    else                  upByte = rxBuf[idx];
    busOut = strobe.hiNib ? upByte[7:4] : upByte[3:0];
  end

  AST_WE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memWr && memAddr != '0) |=> !regs[0][WE_BIT]) else $error("we not cleared"); // R8

  AST_SWITCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memWr && memAddr == '0) |=> (regs[0] == $past(asmByte))) else $error("switch write lost"); // R8

endmodule

// File: rtl/nhp_ctrl.sv
module nhp_ctrl
  import nhp_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int TIMEOUT_TICKS = 2900,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReqS,
  input  logic             rxAckS,
  input  logic             msTick,
  input  logic             htoEn,
  input  logic [1:0]       ctlType,
  input  logic [IDX_W-1:0] asmCount,
  input  logic [IDX_W-1:0] rxCount,
  input  logic             rxCommit,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             txAckN,
  output logic             rxReqN,
  output logic             busOe,
  output logic             pktDone
);

  portState_e state, stateN;
  logic [IDX_W-1:0] idxN, lastIdx, lastN, lastB;
  logic hiNib, hiNibN, dataMode, dataN, replyMode, replyN;
  logic oeN, pktDoneN, clearPend, rxPending;
  logic isFirst, isData, isRead;
  logic tmoActive, tmoHit;
  logic [CNT_W-1:0] tmoCnt, tmoN;

  assign txAckN = (state != ST_DL_ACK);
  assign rxReqN = (state != ST_UL_REQ);

  always_comb begin
    stateN = state;
    idxN = idx;
    lastN = lastIdx;
    hiNibN = hiNib;
    dataN = dataMode;
    replyN = replyMode;
    oeN = busOe;
    pktDoneN = 1'b0;
    clearPend = 1'b0;
    strobe = '0;
    strobe.hiNib = hiNib;
    strobe.replyMode = replyMode;

    isFirst = (idx == '0);
    isData = dataMode;
    lastB = lastIdx;
    if (isFirst) begin
      isData = !ctlType[1];
      lastB = ctlType[1] ? (ctlType[0] ? IDX_W'(1) : '0) : asmCount;
    end
    isRead = isFirst && ctlType[1] && !ctlType[0];

    unique case (state)
      ST_IDLE: begin
        if (rxPending) begin
          stateN = ST_UL_REQ;
          idxN = '0;
          hiNibN = 1'b0;
          replyN = 1'b0;
          lastN = rxCount;
        end else if (!txReqS) begin
          stateN = ST_DL_ACK;
          idxN = '0;
          hiNibN = 1'b0;
        end
      end
      ST_DL_WAIT: begin
        if (!txReqS) stateN = ST_DL_ACK;
      end
      ST_DL_ACK: begin
        if (txReqS) begin
          if (!hiNib) begin
            strobe.latchLo = 1'b1;
            hiNibN = 1'b1;
            stateN = ST_DL_WAIT;
          end else begin
            strobe.byteDone = 1'b1;
            strobe.dataWr = isData;
            hiNibN = 1'b0;
            dataN = isData;
            lastN = lastB;
            if (idx == lastB) begin
              if (isRead) begin
                stateN = ST_UL_REQ;
                idxN = '0;
                replyN = 1'b1;
                lastN = IDX_W'(1);
              end else begin
                stateN = ST_IDLE;
                pktDoneN = isData;
                strobe.memWr = !isData;
              end
            end else begin
              idxN = idx + 1'b1;
              stateN = ST_DL_WAIT;
            end
          end
        end
      end
      ST_UL_REQ: begin
        if (!rxAckS) begin
          stateN = ST_UL_DRV;
          oeN = 1'b1;
        end
      end
      ST_UL_DRV: begin
        if (rxAckS) begin
          if (!hiNib) begin
            hiNibN = 1'b1;
            stateN = ST_UL_REQ;
          end else begin
            hiNibN = 1'b0;
            if (idx == lastIdx) begin
              stateN = ST_IDLE;
              oeN = 1'b0;
              clearPend = !replyMode;
            end else begin
              idxN = idx + 1'b1;
              stateN = ST_UL_REQ;
            end
          end
        end
      end
      ST_HOLD: begin
        if (txReqS && rxAckS) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase

    // host timeout: only while a transfer waits on the host
    tmoActive = htoEn && state != ST_IDLE && state != ST_HOLD;
    tmoHit = tmoActive && msTick && tmoCnt == CNT_W'(TIMEOUT_TICKS - 1) && stateN == state;
    if (tmoHit) begin
      stateN = ST_HOLD;
      oeN = 1'b0;
      clearPend = 1'b1;
      hiNibN = 1'b0;
      pktDoneN = 1'b0;
      strobe.latchLo = 1'b0;
      strobe.byteDone = 1'b0;
      strobe.dataWr = 1'b0;
      strobe.memWr = 1'b0;
    end

    if (!tmoActive || stateN != state) tmoN = '0;
    else if (msTick)                   tmoN = tmoCnt + 1'b1;
    else                               tmoN = tmoCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx <= '0;
      lastIdx <= '0;
      hiNib <= 1'b0;
      dataMode <= 1'b0;
      replyMode <= 1'b0;
      busOe <= 1'b0;
      pktDone <= 1'b0;
      rxPending <= 1'b0;
      tmoCnt <= '0;
    end else begin
      state <= stateN;
      idx <= idxN;
      lastIdx <= lastN;
      hiNib <= hiNibN;
      dataMode <= dataN;
      replyMode <= replyN;
      busOe <= oeN;
      pktDone <= pktDoneN;
      tmoCnt <= tmoN;
      if (rxCommit)       rxPending <= 1'b1;
      else if (clearPend) rxPending <= 1'b0;
    end
  end

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txAckN) |-> $past(!txReqS)) else $error("accept without request"); // R2

  AST_RX_BEFORE_TX: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txAckN) && $past(state == ST_IDLE)) |-> !$past(rxPending)) else $error("download granted over pending packet"); // R9

  AST_DRIVE_IN_UPLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UL_DRV) |-> busOe) else $error("bus not driven"); // R5

  AST_QUIET_OUTSIDE_UPLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_DL_WAIT || state == ST_DL_ACK || state == ST_HOLD) |-> !busOe) else $error("bus driven outside upload"); // R5

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(tmoCnt) < TIMEOUT_TICKS) else $error("timeout counter overran"); // R10

  AST_HOLD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (txAckN && rxReqN && !busOe)) else $error("lines held after abort"); // R10

endmodule

// File: rtl/nibble_host_port.sv
module nibble_host_port
  import nhp_pkg::*;
#(
  parameter int MAX_DATA = 27,
  parameter int TIMEOUT_TICKS = 2900,
  localparam int IDX_W = $clog2(MAX_DATA + 1),
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             txReqN,
  output logic             txAckN,
  output logic             rxReqN,
  input  logic             rxAckN,
  input  logic [3:0]       busIn,
  output logic [3:0]       busOut,
  output logic             busOe,
  input  logic             rxWrEn,
  input  logic [IDX_W-1:0] rxWrAddr,
  input  logic [7:0]       rxWrData,
  input  logic             rxCommit,
  output logic             bufWrEn,
  output logic [IDX_W-1:0] bufWrAddr,
  output logic [7:0]       bufWrData,
  output logic             pktDone
);

  logic [1:0] hsSync;
  dpStrobe_t strobe;
  logic [IDX_W-1:0] idx, asmCount, rxCount;
  logic [1:0] ctlType;
  logic htoEn;

  nhp_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rstN(rstN), .din({txReqN, rxAckN}), .dout(hsSync)
  );

  nhp_ctrl #(.IDX_W(IDX_W), .TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txReqS(hsSync[1]), .rxAckS(hsSync[0]),
    .msTick(msTick), .htoEn(htoEn), .ctlType(ctlType), .asmCount(asmCount),
    .rxCount(rxCount), .rxCommit(rxCommit), .strobe(strobe), .idx(idx),
    .txAckN(txAckN), .rxReqN(rxReqN), .busOe(busOe), .pktDone(pktDone)
  );

  nhp_datapath #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .strobe(strobe), .idx(idx),
    .ctlType(ctlType), .asmCount(asmCount), .rxCount(rxCount), .htoEn(htoEn),
    .busOut(busOut), .rxWrEn(rxWrEn), .rxWrAddr(rxWrAddr), .rxWrData(rxWrData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

endmodule

// File: tb/nibble_host_port_tb.sv
module nibble_host_port_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, msTick, txReqN, rxAckN, rxWrEn, rxCommit;
  logic txAckN, rxReqN, busOe, bufWrEn, pktDone;
  logic [3:0] busIn, busOut;
  logic [4:0] rxWrAddr, bufWrAddr;
  logic [7:0] rxWrData, bufWrData;

  nibble_host_port u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .txReqN(txReqN), .txAckN(txAckN),
    .rxReqN(rxReqN), .rxAckN(rxAckN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rxWrEn(rxWrEn), .rxWrAddr(rxWrAddr), .rxWrData(rxWrData), .rxCommit(rxCommit),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .pktDone(pktDone)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] got [0:31];
  int wrCount = 0;
  int doneCount = 0;
  logic oeSeen;

  // {addr[5:0], data[7:0], setWe, expected readback[7:0]}
  localparam logic [22:0] VECS [0:4] = '{
    {6'h10, 8'h5A, 1'b1, 8'h5A},
    {6'h20, 8'h33, 1'b0, 8'h00},
    {6'h3F, 8'hC3, 1'b1, 8'hC3},
    {6'h01, 8'h77, 1'b0, 8'h00},
    {6'h10, 8'hE7, 1'b0, 8'h5A}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (bufWrEn) begin
        got[bufWrAddr] = bufWrData;
        wrCount++;
      end
      if (pktDone) doneCount++;
    end
  end

  task automatic waitTxAck(input logic v);
    int n = 0;
    while (txAckN !== v && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 6000) check("R2", "txAckN handshake stalled", int'(txAckN), int'(v));
  endtask

  task automatic waitRxReq(input logic v);
    int n = 0;
    while (rxReqN !== v && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 6000) check("R5", "rxReqN handshake stalled", int'(rxReqN), int'(v));
  endtask

  task automatic sendNib(input logic [3:0] n);
    @(negedge clk);
    txReqN = 1'b0;
    waitTxAck(1'b0);
    busIn = n;
    @(negedge clk);
    txReqN = 1'b1;
    waitTxAck(1'b1);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendNib(b[3:0]);
    sendNib(b[7:4]);
  endtask

  task automatic recvNib(output logic [3:0] n);
    waitRxReq(1'b0);
    @(negedge clk);
    rxAckN = 1'b0;
    waitRxReq(1'b1);
    @(negedge clk);
    n = busOut;
    oeSeen = oeSeen & busOe;
    rxAckN = 1'b1;
  endtask

  task automatic recvByte(output logic [7:0] b);
    logic [3:0] lo, hi;
    recvNib(lo);
    recvNib(hi);
    b = {hi, lo};
  endtask

  task automatic memWrite(input logic [5:0] a, input logic [7:0] d);
    sendByte({2'b11, a});
    sendByte(d);
  endtask

  task automatic memRead(input logic [5:0] a, output logic [7:0] echo, output logic [7:0] d);
    sendByte({2'b10, a});
    recvByte(echo);
    recvByte(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] e, d, b;
    logic [22:0] v;
    rstN = 1'b0; msTick = 1'b1; txReqN = 1'b1; rxAckN = 1'b1; busIn = '0;
    rxWrEn = 1'b0; rxWrAddr = '0; rxWrData = '0; rxCommit = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "txAckN in reset", int'(txAckN), 1);
    check("R1", "rxReqN in reset", int'(rxReqN), 1);
    check("R1", "busOe in reset", int'(busOe), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "txAckN after reset", int'(txAckN), 1);
    memRead(6'h00, e, d);
    check("R1", "switch reset value", int'(d), 0);
    memRead(6'h2A, e, d);
    check("R1", "register reset value", int'(d), 0);

    // vector table: guarded memory writes with readback
    for (int i = 0; i < 5; i++) begin
      v = VECS[i];
      if (v[8]) memWrite(6'h00, 8'h01);
      memWrite(v[22:17], v[16:9]);
      repeat (20) @(negedge clk);
      check("R7", "no reply after memory write", int'(rxReqN), 1);
      oeSeen = 1'b1;
      memRead(v[22:17], e, d);
      check("R6", "read echo of control byte", int'(e), int'({2'b10, v[22:17]}));
      check("R8", "guarded write readback", int'(d), int'(v[7:0]));
      check("R5", "bus driven during reply", int'(oeSeen), 1);
      memRead(6'h00, e, d);
      check("R8", "write enable bit after write", int'(d[0]), 0);
    end

    // data packet of three bytes
    wrCount = 0; doneCount = 0;
    sendByte(8'h03); sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3);
    repeat (4) @(negedge clk);
    check("R4", "buffer writes for length 3", wrCount, 4);
    check("R4", "pktDone pulses", doneCount, 1);
    check("R4", "control byte at address 0", int'(got[0]), 8'h03);
    check("R3", "nibble order byte 1", int'(got[1]), 8'hA1);
    check("R3", "nibble order byte 3", int'(got[3]), 8'hC3);
    check("R2", "accept released after packet", int'(txAckN), 1);

    // length zero
    wrCount = 0; doneCount = 0;
    sendByte(8'h00);
    repeat (4) @(negedge clk);
    check("R4", "buffer writes for length 0", wrCount, 1);
    check("R4", "pktDone for length 0", doneCount, 1);

    // over-long length clamps to 27
    wrCount = 0; doneCount = 0;
    sendByte(8'h1F);
    for (int i = 1; i <= 27; i++) sendByte(8'(i));
    repeat (20) @(negedge clk);
    check("R4", "buffer writes for clamped length", wrCount, 28);
    check("R4", "last clamped byte", int'(got[27]), 27);
    check("R4", "pktDone for clamped length", doneCount, 1);
    check("R4", "no grant beyond clamp", int'(txAckN), 1);

    // pending received packet beats a held download request
    @(negedge clk);
    rxWrEn = 1'b1; rxWrAddr = 5'd0; rxWrData = 8'h02;
    @(negedge clk);
    rxWrAddr = 5'd1; rxWrData = 8'h11;
    @(negedge clk);
    rxWrAddr = 5'd2; rxWrData = 8'h22;
    @(negedge clk);
    rxWrEn = 1'b0; rxCommit = 1'b1;
    @(negedge clk);
    rxCommit = 1'b0;
    txReqN = 1'b0;
    repeat (30) @(negedge clk);
    check("R9", "upload requested first", int'(rxReqN), 0);
    check("R9", "download held back", int'(txAckN), 1);
    oeSeen = 1'b1;
    recvByte(b);
    check("R9", "uploaded control byte", int'(b), 8'h02);
    recvByte(b);
    check("R3", "uploaded byte 1", int'(b), 8'h11);
    recvByte(b);
    check("R9", "uploaded byte 2", int'(b), 8'h22);
    check("R5", "bus driven through upload", int'(oeSeen), 1);
    repeat (3) @(negedge clk);
    check("R5", "bus released after upload", int'(busOe), 0);
    repeat (5) @(negedge clk);
    check("R9", "held request granted after upload", int'(txAckN), 0);
    wrCount = 0;
    sendByte(8'h01); sendByte(8'h99);
    repeat (4) @(negedge clk);
    check("R9", "download after upload", int'(got[1]), 8'h99);
    check("R9", "no second upload", int'(rxReqN), 1);

    // host timeout enabled
    memWrite(6'h00, 8'h02);
    @(negedge clk);
    txReqN = 1'b0;
    waitTxAck(1'b0);
    repeat (2800) @(negedge clk);
    check("R10", "still waiting before limit", int'(txAckN), 0);
    repeat (200) @(negedge clk);
    check("R10", "accept released on timeout", int'(txAckN), 1);
    check("R10", "bus off on timeout", int'(busOe), 0);
    repeat (20) @(negedge clk);
    check("R10", "no regrant while request held", int'(txAckN), 1);
    txReqN = 1'b1;
    repeat (10) @(negedge clk);
    memWrite(6'h00, 8'h00);

    // host timeout disabled: wait without limit
    @(negedge clk);
    txReqN = 1'b0;
    waitTxAck(1'b0);
    repeat (3500) @(negedge clk);
    check("R10", "no timeout when disabled", int'(txAckN), 0);
    busIn = 4'h0;
    @(negedge clk);
    txReqN = 1'b1;
    waitTxAck(1'b1);
    sendNib(4'hC);
    sendByte(8'h00);
    memRead(6'h00, e, d);
    check("R8", "switch write after long stall", int'(d), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule